// File: doc/BRIEF.md
# Burst Column Sequencer for Synchronous DRAM

This block produces one column address per data beat of a memory burst. A column command pulses `start_i` together with the first column, a length code and an ordering select. The block stores these values. From the next clock on it presents one beat per cycle, each with its column, a valid strobe and a final-beat flag. The caller places the presented column on the array's column path and moves data in the same cycle.

Burst lengths of 1, 2, 4 and 8 beats stay inside an aligned block of that size. Only the low column bits change, in either ascending-wrap order or exclusive-OR order. A full-row burst walks all columns of the row upward, wraps at the top, and continues until a stop strobe arrives. A new start replaces a burst that is still running, beginning on the next clock. A stop removes the current beat at once.

Top module: `sdram_colseq`

## Requirements
- R1: While reset is asserted and after its release with no start, `beat_vld_o` and `beat_last_o` are low.
- R2: A cycle with `start_i` high is followed, on the next clock, by beat 0, whose column equals the sampled `start_col_i`.
- R3: Length codes decode as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats and 7 = full row. The reserved codes 4, 5 and 6 act as 1 beat. A fixed-length burst presents its beats on consecutive cycles, and then `beat_vld_o` falls.
- R4: For lengths 2, 4 and 8, the column bits above the low 1, 2 or 3 bits equal those of the start column on every beat.
- R5: With `order_i` = 0 (ascending), the low bits of beat i equal (start low bits + i) modulo the length.
- R6: With `order_i` = 1 (exclusive-OR), the low bits of beat i equal start low bits XOR i.
- R7: A full-row burst presents column (start + i) modulo 512 and ignores `order_i`. It never asserts `beat_last_o`.
- R8: `beat_last_o` is high only on the final beat of a fixed-length burst. A 1-beat burst flags last on its only beat.
- R9: In any cycle with `stop_i` high, `beat_vld_o` and `beat_last_o` are low. No further beat follows unless a new start is given.
- R10: A start during a running burst abandons it. The new burst's beat 0 appears on the next clock. A start in the same cycle as a stop still launches the new burst.
- R11: Changes to `start_col_i`, `len_code_i` and `order_i` without `start_i` have no effect on a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command: load and begin a burst |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 = ascending wrap, 1 = exclusive-OR order |
| stop_i | input | 1 | Burst terminate strobe |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter or stored start column shows on `col_o` in the very cycle it is wrong, because the column is formed without a register from that state. A bad length decode shows as a misplaced or missing `beat_last_o`, or as `beat_vld_o` staying high too long. Both appear within at most eight beats for fixed lengths. A full-row wrap fault appears only after the counter crosses column 511, so one long run crosses the row end. Stop handling is visible in the same cycle as the strobe.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam int unsigned MAX_COL_W = 16;

  typedef logic [MAX_COL_W-1:0] wide_col_t;

  typedef enum logic {
    ORD_ASC = 1'b0,
    ORD_XOR = 1'b1
  } order_e;

  localparam logic [2:0] CODE_ROW = 3'd7;

  // log2 of the beat count for fixed-length codes; reserved codes give 0
  function automatic logic [3:0] code_log2(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd1;
      3'd2:    return 4'd2;
      3'd3:    return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic code_is_row(input logic [2:0] code);
    return code == CODE_ROW;
  endfunction

  // Column of a beat: bits under the mask move, bits above stay at base
  function automatic wide_col_t beat_column(input wide_col_t base,
                                            input wide_col_t beat,
                                            input wide_col_t mask,
                                            input logic      xor_mode);
    wide_col_t moved;
    moved = xor_mode ? (base ^ beat) : (base + beat);
    return (base & ~mask) | (moved & mask);
  endfunction

endpackage

// File: rtl/colseq_len_dec.sv
module colseq_len_dec #(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       len_code_i,
  output logic [COL_W-1:0] span_mask_o,
  output logic             row_mode_o
);
  import colseq_pkg::*;

  logic [3:0]  lg;
  logic [31:0] fixed_mask;

  always_comb begin
    lg          = code_log2(len_code_i);
    fixed_mask  = (32'd1 << lg) - 32'd1;
    row_mode_o  = code_is_row(len_code_i);
    span_mask_o = row_mode_o ? {COL_W{1'b1}} : COL_W'(fixed_mask);
  end

endmodule

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] span_mask_i,
  input  logic             row_mode_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [2:0]       code_o,
  output logic             order_o,
  output logic             at_final_o,
  output logic             beat_vld_o,
  output logic             beat_last_o
);

  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [2:0]       code_q;
  logic             order_q;
  logic             ends_now;

  // final index of a power-of-two span equals its mask
  assign at_final_o  = active_q & ~row_mode_i & (beat_q == span_mask_i);
  assign ends_now    = stop_i | at_final_o;
  assign beat_vld_o  = active_q & ~stop_i;
  assign beat_last_o = at_final_o & ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      code_q   <= '0;
      order_q  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      code_q   <= len_code_i;
      order_q  <= order_i;
    end else if (active_q && ends_now) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign code_o   = code_q;
  assign order_o  = order_q;

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_q && beat_q == '0 && base_q == $past(start_col_i));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i && !ends_now) |=> beat_q == $past(beat_q) + 1'b1);

  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !active_q);

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i) |=> $stable(base_q) && $stable(code_q) && $stable(order_q));

endmodule

// File: rtl/colseq_addr_map.sv
module colseq_addr_map #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] span_mask_i,
  input  logic             order_i,
  input  logic             row_mode_i,
  output logic [COL_W-1:0] col_o
);
  import colseq_pkg::*;

  logic      xor_mode;
  wide_col_t wide;

  // a full-row burst always counts upward
  assign xor_mode = (order_e'(order_i) == ORD_XOR) & ~row_mode_i;

  always_comb begin
    wide  = beat_column(wide_col_t'(base_i), wide_col_t'(beat_i),
                        wide_col_t'(span_mask_i), xor_mode);
    col_o = COL_W'(wide);
  end

endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o
);

  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [2:0]       code_q;
  logic             order_q;
  logic [COL_W-1:0] span_mask;
  logic             row_mode;
  logic             at_final;

  colseq_len_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i (code_q),
    .span_mask_o(span_mask),
    .row_mode_o (row_mode)
  );

  colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .len_code_i (len_code_i),
    .order_i    (order_i),
    .stop_i     (stop_i),
    .span_mask_i(span_mask),
    .row_mode_i (row_mode),
    .active_o   (active),
    .beat_o     (beat),
    .base_o     (base),
    .code_o     (code_q),
    .order_o    (order_q),
    .at_final_o (at_final),
    .beat_vld_o (beat_vld_o),
    .beat_last_o(beat_last_o)
  );

  colseq_addr_map #(.COL_W(COL_W)) u_map (
    .base_i     (base),
    .beat_i     (beat),
    .span_mask_i(span_mask),
    .order_i    (order_q),
    .row_mode_i (row_mode),
    .col_o      (col_o)
  );

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !row_mode) |-> ((col_o ^ base) & ~span_mask) == '0);

  assert_row_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_mode |-> !beat_last_o);

  assert_last_is_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_vld_o);

  assert_single_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && span_mask == '0) |-> beat_last_o);

  assert_stop_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !beat_vld_o && !beat_last_o);

  assert_final_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_final && !start_i) |=> !active);

endmodule

// File: tb/sdram_colseq_bench.sv
`timescale 1ns/1ps
module sdram_colseq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       beat_vld_o;
  logic       beat_last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit m_act = 0;
  int m_beat = 0, m_base = 0, m_code = 0, m_ord = 0;

  always #2.5 clk = ~clk;

  sdram_colseq u_sdram_colseq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o));

  function automatic int beats_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_col(int b, int i, int code, int ord);
    int n, off;
    n = beats_of(code);
    if (code == 7) return (b + i) % 512;
    off = b % n;
    if (ord != 0) return (b - off) + (off ^ i);
    return (b - off) + ((off + i) % n);
  endfunction

  task automatic compare(string tag);
    bit e_vld, e_last;
    int e_col;
    e_vld  = m_act && !stop_i;
    e_last = e_vld && m_code != 7 && m_beat == beats_of(m_code) - 1;
    e_col  = ref_col(m_base, m_beat, m_code, m_ord);
    checks++;
    if (beat_vld_o !== e_vld || beat_last_o !== e_last ||
        (e_vld && int'(col_o) != e_col)) begin
      fails++;
      $display("FAIL %s vld=%0b/%0b last=%0b/%0b col=%0d/%0d (actual/expected)",
               tag, beat_vld_o, e_vld, beat_last_o, e_last, col_o, e_col);
    end
  endtask

  task automatic step(bit s, int c, int l, bit o, bit p, string tag);
    start_i = s; start_col_i = 9'(c); len_code_i = 3'(l);
    order_i = o; stop_i = p;
    #1;
    compare(tag);
    @(posedge clk);
    if (s) begin
      m_act = 1; m_beat = 0; m_base = c; m_code = l; m_ord = o;
    end else if (m_act && (p || (m_code != 7 && m_beat == beats_of(m_code) - 1))) begin
      m_act = 0;
    end else if (m_act) begin
      m_beat = (m_beat + 1) % 512;
    end
    @(negedge clk);
  endtask

  // idle cycles that scramble the configuration inputs (R11)
  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++)
      step(0, int'($urandom_range(0, 511)), int'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C01));
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      #1; checks++;
      if (beat_vld_o !== 1'b0 || beat_last_o !== 1'b0) begin
        fails++;
        $display("FAIL R1 vld=%0b last=%0b expected 0/0", beat_vld_o, beat_last_o);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");

    step(1, 5, 0, 0, 0, "R2");       run(3, "R8 single");
    step(1, 9'h0FF, 1, 0, 0, "R2");  run(3, "R5 len2");
    step(1, 9'h1A6, 2, 0, 0, "R5");  run(5, "R5 len4");
    step(1, 9'h0C5, 3, 1, 0, "R6");  run(9, "R6 len8");
    step(1, 9'h13E, 3, 0, 0, "R5");  run(9, "R4 len8");
    step(1, 9'h077, 2, 1, 0, "R6");  run(5, "R6 len4");
    step(1, 9'h042, 5, 0, 0, "R3");  run(2, "R3 reserved");
    step(1, 9'h1FD, 7, 1, 0, "R7");  run(10, "R7 wrap");
    step(0, 0, 0, 0, 1, "R9");       run(3, "R9 after stop");
    step(1, 9'h010, 3, 0, 0, "R10"); run(2, "R10");
    step(1, 9'h101, 2, 0, 0, "R10"); run(5, "R10 restart");
    step(1, 9'h020, 3, 1, 0, "R10"); run(1, "R10");
    step(1, 9'h033, 1, 0, 1, "R10"); run(3, "R10 start over stop");
    step(1, 9'h000, 7, 0, 0, "R7");  run(520, "R7 full row");
    step(0, 0, 0, 0, 1, "R9");       run(2, "R9");
    step(1, 9'h0A8, 3, 0, 0, "R9");  run(2, "R9");
    step(0, 0, 0, 0, 1, "R9 mid");   run(3, "R9 mid");

    for (int k = 0; k < 3000; k++)
      step(($urandom_range(0, 5) == 0), int'($urandom_range(0, 511)),
           int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 11) == 0), "R5/R6 random");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule